// File: doc/BRIEF.md
# BCD calendar time counter

This block keeps wall-clock time and calendar date for a chip: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Each one-cycle pulse on `tick_1hz` moves the time forward by one second. Carries run from seconds through minutes and hours into the date fields. The month length follows the calendar, including February in leap years. The two-digit year stands for a year from 1950 to 2049: stored values 50 to 99 mean 1950 to 1999, and 00 to 49 mean 2000 to 2049. Inside that window a year is a leap year exactly when the stored value is divisible by four.

Every field is stored in the encoding picked by `bcd_mode`: packed BCD (tens digit in bits 7:4, units digit in bits 3:0) or plain binary. To advance the time, the block decodes each field to binary, increments the whole date in binary, and re-encodes the result in the current mode. Software sets the time through a write port that loads one field byte per transfer. While it does so, it raises `hold` to stop the count. Hours always run in 24-hour form.

The write port is a valid/ready channel whose `wr_ready` is always high. A transfer completes in every cycle in which `wr_valid` is high, and the block never applies back-pressure. All seven field bytes are always visible on `fields_q`, with byte k at register address k.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the fields read 00:00:00, weekday 7, day 1, month 1, year 00. `fields_q[8k+7:8k]` is the field at address k, and the addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year.
- R2: With `bcd_mode`=1, fields are packed BCD with the tens digit in bits 7:4. A tick takes seconds 0x09 to 0x10. From 0x59 a tick goes to 0x00 and adds one to the minutes.
- R3: With `bcd_mode`=0, fields are plain binary. A tick takes seconds 9 to 10 (0x0A). From 59 (0x3B) a tick goes to 0 and adds one to the minutes.
- R4: Hours count 0 to 23. A tick at 23:59:59 gives 00:00:00 and advances the date.
- R5: Weekday runs 1 to 7, where 1 is Sunday. It steps by one each time the day of month advances, and wraps from 7 to 1.
- R6: Months 4, 6, 9 and 11 have 30 days and the other months except February have 31. A tick at 23:59:59 on the last day of a month gives day 1 of the next month. Month is stored as 1 to 12.
- R7: February has 29 days when the stored year is divisible by 4 (including 00) and 28 days otherwise.
- R8: A tick at 23:59:59 on 31 December of stored year 99 gives 1 January of year 00.
- R9: While `hold`=1, ticks have no effect on any field. Writes are still accepted.
- R10: A transfer with `wr_addr` 0 to 6 replaces that field with `wr_data` as written, visible one cycle later. A transfer to address 7 changes nothing. `wr_ready` is 1 at all times.
- R11: When a write to addresses 0 to 6 and a tick come in the same cycle, the write lands and the tick is dropped, so no other field changes.
- R12: A tick is sampled on each rising clock edge and its result shows one cycle later. A tick held high for N cycles advances the time by N seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-second advance strobe |
| bcd_mode | input | 1 | 1 = packed BCD fields, 0 = binary fields |
| hold | input | 1 | Freeze the count while the time is being set |
| wr_valid | input | 1 | Write transfer valid |
| wr_ready | output | 1 | Write transfer ready (always 1) |
| wr_addr | input | 3 | Field address of the write |
| wr_data | input | 8 | Field byte to store |
| fields_q | output | 56 | All field bytes, byte k = address k |

## Verification
A wrong carry or a wrong month length in the date logic shows up only at a rollover. A free-running count would take up to a simulated century to reach some of these rollovers, so the bench writes the time directly to one second before each boundary. A single tick then exposes the fault on `fields_q` one cycle later. Encoding faults appear on the first tick whose units digit passes 9 in BCD mode, or passes 9 in binary mode. Arbitration faults (hold, or a write colliding with a tick) leave a field one second off in the cycle right after the event.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 7;
  localparam int ADDR_W     = 3;

  localparam int A_SEC  = 0;
  localparam int A_MIN  = 1;
  localparam int A_HOUR = 2;
  localparam int A_WDAY = 3;
  localparam int A_MDAY = 4;
  localparam int A_MON  = 5;
  localparam int A_YEAR = 6;

  typedef logic [FIELD_W-1:0] fld_t;
  typedef fld_t [NUM_FIELDS-1:0] fld_vec_t;

  localparam fld_t SEC_LAST  = 8'd59;
  localparam fld_t MIN_LAST  = 8'd59;
  localparam fld_t HOUR_LAST = 8'd23;
  localparam fld_t WDAY_LAST = 8'd7;
  localparam fld_t MON_LAST  = 8'd12;
  localparam fld_t YEAR_LAST = 8'd99;

  // Binary 0..99 to packed BCD
  function automatic fld_t bin_to_bcd(input fld_t v);
    fld_t tens;
    fld_t ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  // Packed BCD to binary
  function automatic fld_t bcd_to_bin(input fld_t v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction
endpackage

// File: rtl/rtc_field_codec.sv
module rtc_field_codec
  import rtc_cal_pkg::*;
(
  input  logic bcd_mode,
  input  fld_t raw_in,
  output fld_t bin_out,
  input  fld_t bin_in,
  output fld_t raw_out
);
  // Stored byte -> working binary value
  always_comb begin
    if (bcd_mode) bin_out = bcd_to_bin(raw_in);
    else          bin_out = raw_in;
  end

  // Working binary value -> stored byte
  always_comb begin
    if (bcd_mode) raw_out = bin_to_bcd(bin_in);
    else          raw_out = bin_in;
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_cal_pkg::*;
(
  input  fld_t month,
  input  fld_t year,
  output fld_t days
);
  logic leap;

  // Window 1950..2049: 1900 and 2000 are both multiples of 4
  assign leap = (year[1:0] == 2'b00);

  always_comb begin
    unique case (month)
      8'd2:                    days = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: days = 8'd30;
      default:                 days = 8'd31;
    endcase
  end
endmodule

// File: rtl/rtc_carry_chain.sv
module rtc_carry_chain
  import rtc_cal_pkg::*;
(
  input  fld_vec_t cur,
  output fld_vec_t nxt
);
  fld_t dim;
  logic c_min, c_hour, c_day, c_mon, c_year;

  rtc_month_len u_mlen (
    .month (cur[A_MON]),
    .year  (cur[A_YEAR]),
    .days  (dim)
  );

  // Carry terms; out-of-range values wrap like the last value
  assign c_min  = (cur[A_SEC]  >= SEC_LAST);
  assign c_hour = c_min  && (cur[A_MIN]  >= MIN_LAST);
  assign c_day  = c_hour && (cur[A_HOUR] >= HOUR_LAST);
  assign c_mon  = c_day  && (cur[A_MDAY] >= dim);
  assign c_year = c_mon  && (cur[A_MON]  >= MON_LAST);

  always_comb begin
    nxt = cur;
    nxt[A_SEC] = c_min ? 8'd0 : cur[A_SEC] + 8'd1;
    if (c_min)
      nxt[A_MIN] = c_hour ? 8'd0 : cur[A_MIN] + 8'd1;
    if (c_hour)
      nxt[A_HOUR] = c_day ? 8'd0 : cur[A_HOUR] + 8'd1;
    if (c_day) begin
      nxt[A_WDAY] = (cur[A_WDAY] >= WDAY_LAST) ? 8'd1 : cur[A_WDAY] + 8'd1;
      nxt[A_MDAY] = c_mon ? 8'd1 : cur[A_MDAY] + 8'd1;
    end
    if (c_mon)
      nxt[A_MON] = c_year ? 8'd1 : cur[A_MON] + 8'd1;
    if (c_year)
      nxt[A_YEAR] = (cur[A_YEAR] >= YEAR_LAST) ? 8'd0 : cur[A_YEAR] + 8'd1;
  end

  // R4: a legal hour never steps out of 0..23
  always_comb begin
    if (cur[A_HOUR] <= HOUR_LAST)
      assert_hour_range_R4: assert (nxt[A_HOUR] <= HOUR_LAST);
  end

  // R5: a legal weekday stays within 1..7
  always_comb begin
    if (cur[A_WDAY] >= 8'd1 && cur[A_WDAY] <= WDAY_LAST)
      assert_wday_range_R5: assert (nxt[A_WDAY] >= 8'd1 && nxt[A_WDAY] <= WDAY_LAST);
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick_1hz,
  input  logic                          bcd_mode,
  input  logic                          hold,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [FIELD_W-1:0]            wr_data,
  output logic [NUM_FIELDS*FIELD_W-1:0] fields_q
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_FIELDS - 1);

  fld_vec_t fld_q;
  fld_vec_t bin_cur;
  fld_vec_t bin_nxt;
  fld_vec_t raw_nxt;
  logic     wr_hit;
  logic     advance;
  logic [NUM_FIELDS*FIELD_W-1:0] other_mask;

  assign wr_ready = 1'b1;
  assign wr_hit   = wr_valid && (wr_addr <= LAST_ADDR);
  assign advance  = tick_1hz && !hold && !wr_hit;

  // One codec per field
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_codec
    rtc_field_codec u_codec (
      .bcd_mode (bcd_mode),
      .raw_in   (fld_q[g]),
      .bin_out  (bin_cur[g]),
      .bin_in   (bin_nxt[g]),
      .raw_out  (raw_nxt[g])
    );
  end

  rtc_carry_chain u_chain (
    .cur (bin_cur),
    .nxt (bin_nxt)
  );

  // Reset values are below ten, so they read the same in both encodings
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld_q         <= '0;
      fld_q[A_WDAY] <= 8'd7;
      fld_q[A_MDAY] <= 8'd1;
      fld_q[A_MON]  <= 8'd1;
    end else if (wr_hit) begin
      fld_q[wr_addr] <= wr_data;
    end else if (advance) begin
      fld_q <= raw_nxt;
    end
  end

  assign fields_q = fld_q;

  // Bytes not addressed by the current write
  always_comb begin
    for (int k = 0; k < NUM_FIELDS; k++)
      other_mask[k*FIELD_W +: FIELD_W] = (wr_addr == ADDR_W'(k)) ? '0 : '1;
  end

  // R9: hold with no write keeps every field
  assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_hit) |=> $stable(fields_q));

  // R10: a write lands in its field
  assert_write_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (fld_q[$past(wr_addr)] == $past(wr_data)));

  // R11: a write, with or without a tick, leaves the other fields alone
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((fields_q & $past(other_mask)) == $past(fields_q & other_mask)));

  // R12: an accepted tick below the minute boundary adds one second
  assert_sec_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && bin_cur[A_SEC] < SEC_LAST) |=>
      ((bcd_mode != $past(bcd_mode)) || (bin_cur[A_SEC] == $past(bin_cur[A_SEC]) + 8'd1)));
endmodule

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        bcd_mode = 1'b1;
  logic        hold = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [55:0] fields_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  rtc_calendar_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bcd_mode(bcd_mode),
    .hold(hold), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .fields_q(fields_q)
  );

  function automatic logic [7:0] fb(input int a);
    return fields_q[a*8 +: 8];
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // year, month, mday, wday, hour, min, sec
  task automatic set_time(input logic [7:0] y, mo, md, wd, h, mi, s);
    wr(3'd6, y); wr(3'd5, mo); wr(3'd4, md); wr(3'd3, wd);
    wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
  endtask

  task automatic tick1();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "reset fields", {8'h0, fields_q}, 64'h00_00_01_01_07_00_00_00);
    chk("R10", "wr_ready", {63'd0, wr_ready}, 64'd1);
  endtask

  task automatic t_bcd_seconds();
    bcd_mode = 1'b1;
    wr(3'd0, 8'h09); tick1();
    chk("R2", "bcd sec 09->10", fb(0), 8'h10);
    wr(3'd1, 8'h12); wr(3'd0, 8'h59); tick1();
    chk("R2", "bcd sec 59->00", fb(0), 8'h00);
    chk("R2", "bcd min carry", fb(1), 8'h13);
  endtask

  task automatic t_binary();
    bcd_mode = 1'b0;
    wr(3'd0, 8'd9); tick1();
    chk("R3", "bin sec 9->10", fb(0), 8'h0A);
    wr(3'd1, 8'd10); wr(3'd0, 8'd59); tick1();
    chk("R3", "bin sec 59->0", fb(0), 8'h00);
    chk("R3", "bin min carry", fb(1), 8'd11);
    bcd_mode = 1'b1;
  endtask

  task automatic t_hour_wrap();
    set_time(8'h24, 8'h06, 8'h15, 8'h03, 8'h23, 8'h59, 8'h59); tick1();
    chk("R4", "hms wrap", {40'd0, fields_q[23:0]}, 64'h000000);
    chk("R4", "day advance", fb(4), 8'h16);
    chk("R5", "wday 3->4", fb(3), 8'h04);
  endtask

  task automatic t_wday_wrap();
    set_time(8'h24, 8'h06, 8'h10, 8'h07, 8'h23, 8'h59, 8'h59); tick1();
    chk("R5", "wday 7->1", fb(3), 8'h01);
  endtask

  task automatic t_month_len();
    set_time(8'h24, 8'h04, 8'h29, 8'h02, 8'h23, 8'h59, 8'h59); tick1();
    chk("R6", "apr 29->30", fb(4), 8'h30);
    chk("R6", "apr month kept", fb(5), 8'h04);
    tick_to_midnight();
    chk("R6", "apr 30 -> day 1", fb(4), 8'h01);
    chk("R6", "apr -> may", fb(5), 8'h05);
    set_time(8'h24, 8'h01, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59); tick1();
    chk("R6", "jan 31 -> feb 1", {fb(5), fb(4)}, 16'h0201);
  endtask

  task automatic tick_to_midnight();
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59); tick1();
  endtask

  task automatic t_feb();
    set_time(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); tick1();
    chk("R7", "2023 feb 28 -> mar 1", {fb(5), fb(4)}, 16'h0301);
    set_time(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); tick1();
    chk("R7", "2024 feb 28 -> 29", {fb(5), fb(4)}, 16'h0229);
    tick_to_midnight();
    chk("R7", "2024 feb 29 -> mar 1", {fb(5), fb(4)}, 16'h0301);
    set_time(8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); tick1();
    chk("R7", "2000 feb 28 -> 29", {fb(5), fb(4)}, 16'h0229);
  endtask

  task automatic t_year();
    set_time(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59); tick1();
    chk("R8", "bcd new century", {8'h0, fields_q}, 64'h00_00_01_01_06_00_00_00);
    bcd_mode = 1'b0;
    set_time(8'd99, 8'd12, 8'd31, 8'd7, 8'd23, 8'd59, 8'd59); tick1();
    chk("R8", "bin year 99->0", {fb(6), fb(5), fb(4), fb(3)}, 32'h00_01_01_01);
    bcd_mode = 1'b1;
  endtask

  task automatic t_hold();
    logic [55:0] snap;
    set_time(8'h24, 8'h03, 8'h05, 8'h02, 8'h10, 8'h20, 8'h30);
    hold = 1'b1;
    snap = fields_q;
    tick1(); tick1(); tick1();
    chk("R9", "hold blocks ticks", {8'h0, fields_q}, {8'h0, snap});
    wr(3'd0, 8'h45);
    chk("R9", "write under hold", fb(0), 8'h45);
    hold = 1'b0;
    tick1();
    chk("R9", "count resumes", fb(0), 8'h46);
  endtask

  task automatic t_bad_addr();
    logic [55:0] snap;
    snap = fields_q;
    wr(3'd7, 8'hA5);
    chk("R10", "addr 7 ignored", {8'h0, fields_q}, {8'h0, snap});
    wr(3'd2, 8'h17);
    chk("R10", "hour write", fb(2), 8'h17);
  endtask

  task automatic t_collide();
    wr(3'd1, 8'h10); wr(3'd0, 8'h59);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 3'd0; wr_data = 8'h30; tick_1hz = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; tick_1hz = 1'b0;
    chk("R11", "write wins sec", fb(0), 8'h30);
    chk("R11", "tick dropped min", fb(1), 8'h10);
  endtask

  task automatic t_consec();
    wr(3'd0, 8'h00);
    @(negedge clk);
    tick_1hz = 1'b1;
    chk("R12", "no change before edge", fb(0), 8'h00);
    repeat (3) @(negedge clk);
    tick_1hz = 1'b0;
    chk("R12", "three ticks", fb(0), 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bcd_seconds();
    t_binary();
    t_hour_wrap();
    t_wday_wrap();
    t_month_len();
    t_feb();
    t_year();
    t_hold();
    t_bad_addr();
    t_collide();
    t_consec();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule